// File: doc/BRIEF.md
# Vector Lane Conflict Detection Unit

This unit takes a packed vector of integer elements and reports, for every element, which elements of lower index hold the same value. Each element's report is a small bit vector: one bit per lower-indexed element. It is zero-extended to the element width and placed in that element's lane of a 512-bit result. Elements are 32 or 64 bits wide. The vector is 128, 256 or 512 bits long. Everything above the chosen length is cleared.

A per-lane write mask decides which lanes take the new result. A lane with its mask bit clear either keeps the value it had in the destination (merge) or is cleared (zeroing). A broadcast option replaces the whole source vector with one scalar copied into every lane. The unit has one register stage. The result and a valid flag appear on the clock edge after an input strobe and hold until the next strobe.

Top module: `lane_conflict_unit`

## Requirements
- R1: `res_valid` is high for exactly the one cycle that follows a cycle with `in_valid` high. `res_vec` changes only on that edge and holds its value otherwise.
- R2: With `wide` = 0, lane j occupies bits [32j+31:32j]. For every k < j, bit k of lane j is 1 exactly when the 32-bit values of lanes j and k are equal.
- R3: Bits j and above of lane j are always 0, so lane 0 of a written result is always 0.
- R4: With `wide` = 1, lane q occupies bits [64q+63:64q]. For every k < q, bit k of lane q is 1 exactly when all 64 bits of lanes q and k are equal. Equal low halves with different high halves do not count as a match.
- R5: `len_sel` picks the vector length: 0 gives 128 bits, 1 gives 256 bits, 2 or 3 gives 512 bits. All result bits from the chosen length up to bit 511 are 0, whatever the source, old value or mask.
- R6: With `mask_on` = 0, every lane within the length receives its conflict vector, whatever `lane_mask` holds.
- R7: With `mask_on` = 1 and `zero_mode` = 0, a lane whose mask bit is clear takes its bits from `prior_dst`. In 32-bit mode lane j uses mask bit j; in 64-bit mode lane q uses mask bit q.
- R8: With `mask_on` = 1 and `zero_mode` = 1, a lane whose mask bit is clear is written with 0.
- R9: In 64-bit mode, `lane_mask` bits 8 to 15 have no effect on the result.
- R10: With `splat` = 1 and `wide` = 0, `splat_val[31:0]` fills every lane and `vec_in` is ignored. Each unmasked active lane j then equals (1<<j)-1.
- R11: With `splat` = 1 and `wide` = 1, all 64 bits of `splat_val` fill every lane. Each unmasked active lane q then equals (1<<q)-1.
- R12: While `rst` is high, `res_vec` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture a result from the current inputs |
| vec_in | input | 512 | Packed source elements |
| prior_dst | input | 512 | Previous destination value, used for merging |
| lane_mask | input | 16 | Per-lane write mask |
| wide | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| len_sel | input | 2 | Vector length select |
| mask_on | input | 1 | Apply the lane mask |
| zero_mode | input | 1 | Masked-off lanes: 1 clears them, 0 merges `prior_dst` |
| splat | input | 1 | Replace the source with the broadcast scalar |
| splat_val | input | 64 | Broadcast scalar |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| res_vec | output | 512 | Registered result |

## Verification
The case that is hardest to reach from the ports is a 64-bit pair whose low halves match and whose high halves do not. This is the point where the shared 32-bit comparators must be combined correctly. Random data almost never produces it. The bench therefore builds 64-bit lanes with one common low half and high halves that repeat with period three. This makes matching and non-matching pairs sit side by side.

Masking in 64-bit mode is also driven on purpose with only the upper mask bits set. This shows that those bits cannot reach any lane. Length selection is exercised with duplicates placed above the chosen length. If the upper lanes leaked into the result, the checks would see it.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
  localparam int MAX_W = 512;
  localparam int DW    = 32;
  localparam int NDW   = MAX_W / DW;
  localparam int NQW   = NDW / 2;

  // number of 32-bit granules covered by the selected vector length
  function automatic int active_dwords(input logic [1:0] ls);
    case (ls)
      2'd0:    return NDW / 4;
      2'd1:    return NDW / 2;
      default: return NDW;
    endcase
  endfunction
endpackage

// File: rtl/lcu_operand.sv
module lcu_operand #(
  parameter int MAX_W = 512,
  parameter int DW    = 32
) (
  input  logic [MAX_W-1:0] vec_in,
  input  logic             wide,
  input  logic             splat,
  input  logic [2*DW-1:0]  splat_val,
  output logic [MAX_W-1:0] opnd
);
  localparam int NDW = MAX_W / DW;

  for (genvar d = 0; d < NDW; d++) begin : g_dw
    logic [DW-1:0] bval;
    if ((d % 2) == 1) begin : g_odd
      assign bval = wide ? splat_val[2*DW-1:DW] : splat_val[DW-1:0];
    end else begin : g_even
      assign bval = splat_val[DW-1:0];
    end
    assign opnd[d*DW +: DW] = splat ? bval : vec_in[d*DW +: DW];
  end
endmodule

// File: rtl/lcu_eq_matrix.sv
module lcu_eq_matrix #(
  parameter int MAX_W = 512,
  parameter int DW    = 32
) (
  input  logic [MAX_W-1:0]           opnd,
  output logic [(MAX_W/DW)**2-1:0]   eq_flat
);
  localparam int NDW = MAX_W / DW;

  // eq_flat[j*NDW+k] = granule j equals granule k, only for k < j
  for (genvar j = 0; j < NDW; j++) begin : g_row
    for (genvar k = 0; k < NDW; k++) begin : g_col
      if (k < j) begin : g_cmp
        assign eq_flat[j*NDW+k] = (opnd[j*DW +: DW] == opnd[k*DW +: DW]);
      end else begin : g_none
        assign eq_flat[j*NDW+k] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcu_lane_pack.sv
module lcu_lane_pack
  import lcu_pkg::*;
#(
  parameter int MAX_W = 512,
  parameter int DW    = 32
) (
  input  logic [(MAX_W/DW)**2-1:0] eq_flat,
  input  logic                     wide,
  input  logic [1:0]               len_sel,
  input  logic [MAX_W/DW-1:0]      lane_mask,
  input  logic                     mask_on,
  input  logic                     zero_mode,
  input  logic [MAX_W-1:0]         prior_dst,
  output logic [MAX_W-1:0]         nxt
);
  localparam int NDW = MAX_W / DW;

  int n_act;
  assign n_act = active_dwords(len_sel);

  for (genvar d = 0; d < NDW; d++) begin : g_dw
    logic [DW-1:0] dcv, qcv, cv;
    logic          mbit, act;

    always_comb begin
      dcv = '0;
      for (int k = 0; k < d; k++) dcv[k] = eq_flat[d*NDW+k];
    end

    if ((d % 2) == 0) begin : g_qlow
      // 64-bit lane d/2 matches lane k when both halves match
      always_comb begin
        qcv = '0;
        for (int k = 0; k < d/2; k++)
          qcv[k] = eq_flat[d*NDW+2*k] & eq_flat[(d+1)*NDW+2*k+1];
      end
      assign mbit = wide ? lane_mask[d/2] : lane_mask[d];
    end else begin : g_qhigh
      assign qcv  = '0;
      assign mbit = wide ? lane_mask[(d-1)/2] : lane_mask[d];
    end

    assign cv  = wide ? qcv : dcv;
    assign act = (d < n_act);

    always_comb begin
      if (!act)                  nxt[d*DW +: DW] = '0;
      else if (!mask_on || mbit) nxt[d*DW +: DW] = cv;
      else if (zero_mode)        nxt[d*DW +: DW] = '0;
      else                       nxt[d*DW +: DW] = prior_dst[d*DW +: DW];
    end
  end
endmodule

// File: rtl/lane_conflict_unit.sv
module lane_conflict_unit
  import lcu_pkg::*;
#(
  parameter int MAX_W = 512,
  parameter int DW    = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [MAX_W-1:0]   vec_in,
  input  logic [MAX_W-1:0]   prior_dst,
  input  logic [MAX_W/DW-1:0] lane_mask,
  input  logic               wide,
  input  logic [1:0]         len_sel,
  input  logic               mask_on,
  input  logic               zero_mode,
  input  logic               splat,
  input  logic [2*DW-1:0]    splat_val,
  output logic               res_valid,
  output logic [MAX_W-1:0]   res_vec
);
  localparam int NDW = MAX_W / DW;

  logic [MAX_W-1:0]   opnd;
  logic [NDW*NDW-1:0] eq_flat;
  logic [MAX_W-1:0]   nxt;

  lcu_operand #(.MAX_W(MAX_W), .DW(DW)) u_opnd (
    .vec_in(vec_in), .wide(wide), .splat(splat),
    .splat_val(splat_val), .opnd(opnd)
  );

  lcu_eq_matrix #(.MAX_W(MAX_W), .DW(DW)) u_eq (
    .opnd(opnd), .eq_flat(eq_flat)
  );

  lcu_lane_pack #(.MAX_W(MAX_W), .DW(DW)) u_pack (
    .eq_flat(eq_flat), .wide(wide), .len_sel(len_sel),
    .lane_mask(lane_mask), .mask_on(mask_on), .zero_mode(zero_mode),
    .prior_dst(prior_dst), .nxt(nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_vec   <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res_vec <= nxt;
    end
  end

  // R1: valid follows strobe by one cycle; result holds without strobe
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(in_valid));
  a_r1_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_vec));
  // R3: lane 0 of a written result is zero
  a_r3_lane0_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!mask_on || lane_mask[0])) |=> (res_vec[DW-1:0] == '0));
  // R5: 128-bit length clears everything above
  a_r5_len_clear: assert property (@(posedge clk) disable iff (rst)
    (in_valid && len_sel == 2'd0) |=> (res_vec[MAX_W-1:MAX_W/4] == '0));
  // R7: merge keeps old value of masked-off lane 0
  a_r7_merge: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_on && !zero_mode && !lane_mask[0])
      |=> (res_vec[DW-1:0] == $past(prior_dst[DW-1:0])));
  // R8: zeroing clears masked-off lane 0
  a_r8_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_on && zero_mode && !lane_mask[0])
      |=> (res_vec[DW-1:0] == '0));
  // R12: reset state
  a_r12_reset: assert property (@(posedge clk)
    rst |=> (!res_valid && res_vec == '0));
endmodule

// File: tb/sim_lane_conflict_unit.sv
`timescale 1ns/1ps
module sim_lane_conflict_unit;
  logic         clk = 0;
  logic         rst = 1;
  logic         in_valid = 0;
  logic [511:0] vec_in = '0, prior_dst = '0;
  logic [15:0]  lane_mask = '0;
  logic         wide = 0, mask_on = 0, zero_mode = 0, splat = 0;
  logic [1:0]   len_sel = 2'd2;
  logic [63:0]  splat_val = '0;
  logic         res_valid;
  logic [511:0] res_vec;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  lane_conflict_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vec_in(vec_in),
    .prior_dst(prior_dst), .lane_mask(lane_mask), .wide(wide),
    .len_sel(len_sel), .mask_on(mask_on), .zero_mode(zero_mode),
    .splat(splat), .splat_val(splat_val),
    .res_valid(res_valid), .res_vec(res_vec)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %0d cycles exp fewer than 20000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h exp %h", tag, got, exp);
    end
  endtask

  // independent element-level reference
  function automatic logic [511:0] model(
      input logic [511:0] s, input logic [511:0] o, input logic [15:0] m,
      input logic w, input logic [1:0] l, input logic me, input logic zm,
      input logic bc, input logic [63:0] bv);
    logic [511:0] r = '0;
    logic [511:0] v = s;
    int ln = (l == 2'd3) ? 2 : int'(l);
    int nl = (w ? 2 : 4) << ln;
    for (int j = 0; j < nl; j++) begin
      if (bc) begin
        if (w) v[j*64 +: 64] = bv; else v[j*32 +: 32] = bv[31:0];
      end
    end
    for (int j = 0; j < nl; j++) begin
      if (!me || m[j]) begin
        for (int k = 0; k < j; k++) begin
          if (w) r[j*64+k] = (v[j*64 +: 64] == v[k*64 +: 64]);
          else   r[j*32+k] = (v[j*32 +: 32] == v[k*32 +: 32]);
        end
      end else if (!zm) begin
        if (w) r[j*64 +: 64] = o[j*64 +: 64];
        else   r[j*32 +: 32] = o[j*32 +: 32];
      end
    end
    return r;
  endfunction

  // drive one strobe; returns at the negedge after the capturing edge
  task automatic fire();
    @(negedge clk); in_valid = 1;
    @(negedge clk); in_valid = 0;
  endtask

  function automatic logic [511:0] expect_now();
    return model(vec_in, prior_dst, lane_mask, wide, len_sel, mask_on,
                 zero_mode, splat, splat_val);
  endfunction

  function automatic logic [511:0] dword_pat();
    logic [511:0] p;
    for (int j = 0; j < 16; j++) p[j*32 +: 32] = 32'hA000_0000 + (j % 5);
    return p;
  endfunction

  function automatic logic [511:0] qword_pat();
    logic [511:0] p;
    for (int q = 0; q < 8; q++) p[q*64 +: 64] = {32'h0 + (q % 3), 32'h0000_1234};
    return p;
  endfunction

  task automatic t_reset();
    chk("R12 reset res_valid", {511'd0, res_valid}, '0);
    chk("R12 reset res_vec", res_vec, '0);
  endtask

  task automatic t_dword();
    logic [511:0] e;
    wide = 0; len_sel = 2; mask_on = 0; splat = 0; vec_in = dword_pat();
    e = expect_now(); fire();
    chk("R2 dword conflicts", res_vec, e);
    chk("R3 lane0 and upper bits zero", {480'd0, res_vec[31:0]}, '0);
    chk("R2 lane5 equals lane0 -> bit0", {511'd0, res_vec[5*32]}, 512'd1);
    for (int j = 0; j < 16; j++) vec_in[j*32 +: 32] = 32'h5000 + j;
    fire();
    chk("R3 all distinct gives zero", res_vec, '0);
  endtask

  task automatic t_qword();
    logic [511:0] e;
    wide = 1; len_sel = 2; mask_on = 0; splat = 0; vec_in = qword_pat();
    e = expect_now(); fire();
    chk("R4 qword full width compare", res_vec, e);
    chk("R4 lane1 low half match only -> 0", res_vec[127:64], '0);
  endtask

  task automatic t_len();
    logic [511:0] e;
    wide = 0; mask_on = 0; splat = 0; vec_in = dword_pat();
    prior_dst = {16{32'hFFFF_FFFF}};
    len_sel = 0; e = expect_now(); fire();
    chk("R5 len 128 dword", res_vec, e);
    len_sel = 1; e = expect_now(); fire();
    chk("R5 len 256 dword", res_vec, e);
    wide = 1; vec_in = qword_pat(); len_sel = 0; e = expect_now(); fire();
    chk("R5 len 128 qword", res_vec, e);
    wide = 0; vec_in = dword_pat(); len_sel = 3; e = expect_now(); fire();
    chk("R5 len code 3 as 512", res_vec, e);
  endtask

  task automatic t_nomask();
    logic [511:0] e;
    wide = 0; len_sel = 2; splat = 0; vec_in = dword_pat();
    mask_on = 0; lane_mask = 16'h0000; zero_mode = 1; e = expect_now(); fire();
    chk("R6 mask off ignores lane_mask", res_vec, e);
  endtask

  task automatic t_merge();
    logic [511:0] e;
    wide = 0; len_sel = 2; splat = 0; vec_in = dword_pat();
    for (int j = 0; j < 16; j++) prior_dst[j*32 +: 32] = 32'hC0DE_0000 + j;
    mask_on = 1; zero_mode = 0; lane_mask = 16'hA5C3; e = expect_now(); fire();
    chk("R7 merge dword", res_vec, e);
    wide = 1; vec_in = qword_pat(); lane_mask = 16'h0055; e = expect_now(); fire();
    chk("R7 merge qword", res_vec, e);
  endtask

  task automatic t_zero();
    logic [511:0] e;
    wide = 0; len_sel = 2; splat = 0; vec_in = dword_pat();
    mask_on = 1; zero_mode = 1; lane_mask = 16'h3C0F; e = expect_now(); fire();
    chk("R8 zeroing dword", res_vec, e);
  endtask

  task automatic t_qmask_upper();
    logic [511:0] e;
    wide = 1; len_sel = 2; splat = 0; vec_in = qword_pat();
    mask_on = 1; zero_mode = 0;
    for (int j = 0; j < 16; j++) prior_dst[j*32 +: 32] = 32'hBEEF_0000 + j;
    lane_mask = 16'hFF00; fire();
    chk("R9 upper mask bits ignored (merge all)", res_vec, prior_dst);
  endtask

  task automatic t_bcast();
    logic [511:0] e;
    mask_on = 0; len_sel = 2; splat = 1; vec_in = dword_pat();
    wide = 0; splat_val = 64'h1111_2222_3333_4444;
    e = '0;
    for (int j = 0; j < 16; j++) e[j*32 +: 32] = (32'd1 << j) - 1;
    fire();
    chk("R10 broadcast dword", res_vec, e);
    wide = 1; e = '0;
    for (int q = 0; q < 8; q++) e[q*64 +: 64] = (64'd1 << q) - 1;
    fire();
    chk("R11 broadcast qword", res_vec, e);
    splat = 0;
  endtask

  task automatic t_hold();
    logic [511:0] keep;
    wide = 0; len_sel = 2; mask_on = 0; vec_in = dword_pat(); fire();
    chk("R1 valid one cycle after strobe", {511'd0, res_valid}, 512'd1);
    keep = res_vec;
    vec_in = '0;
    @(negedge clk);
    chk("R1 valid drops", {511'd0, res_valid}, '0);
    chk("R1 result held without strobe", res_vec, keep);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    t_dword();
    t_qword();
    t_len();
    t_nomask();
    t_merge();
    t_zero();
    t_qmask_upper();
    t_bcast();
    t_hold();
    summary();
    $finish;
  end
endmodule